// File: doc/BRIEF.md
# Floating-Point Compare Unit with NaN Screening

This unit compares two IEEE-754 operands in either binary32 or binary64 format. It has two ways of reporting the result. A predicate operation writes a lane-wide mask: all ones when the relation holds and all zeros when it does not. A flag operation writes a six-bit status vector that encodes greater, less, equal or unordered. Both kinds of operation take one clock from the `in_valid` cycle to the registered outputs.

Each operand is classified as zero, ordinary, quiet NaN or signalling NaN. Every operation is either signalling or quiet. A signalling operation treats any NaN as an invalid operation. A quiet operation treats only a signalling NaN that way. An invalid operation is reported on `inv_now` and is also collected in a sticky bit that `stat_clr` resets. When the invalid condition is unmasked, the result write is suppressed, and the mask and flags outputs keep their earlier values.

Top module: `fcmp_unit`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. It is quiet when the top fraction bit is 1 and signalling when that bit is 0. In binary32 mode only `opa[31:0]` and `opb[31:0]` are examined, and bits 63:32 have no effect.
- R2: `op_sel` selects the operation: 0 equal, 1 less, 2 less-or-equal, 3 unordered, 4 not-less, 5 not-less-or-equal, 6 signalling flag compare, 7 quiet flag compare. For ordered operands, a predicate that holds writes `res_mask` as 32 ones in the low bits with zeros above in binary32 mode, or 64 ones in binary64 mode. A predicate that fails writes all zeros.
- R3: When either operand is a NaN, predicates 3, 4 and 5 write the all-ones mask for the precision, and predicates 0, 1 and 2 write zeros.
- R4: Predicates 1, 2, 4 and 5 raise invalid for any NaN operand. Predicates 0 and 3 raise invalid only for a signalling NaN.
- R5: For ordered operands, a flag compare writes `flags` as 6'b000000 for greater, 6'b000001 for less and 6'b000100 for equal. The bit assignment is [0] carry, [1] parity, [2] zero, [3] auxiliary, [4] sign and [5] overflow.
- R6: An unordered flag compare writes `flags` = 6'b000111: zero, parity and carry set, and the other three clear.
- R7: Operation 6 raises invalid for any NaN operand. Operation 7 raises invalid only for a signalling NaN. A quiet NaN under operation 7 writes the unordered flags whether or not the condition is masked.
- R8: When invalid is raised and `inv_mask` is 0, `wr_en` stays low and neither `res_mask` nor `flags` changes. When `inv_mask` is 1, the result is written as usual.
- R9: Outputs update on the clock edge that samples `in_valid` high. `wr_en` and `inv_now` are high for that one cycle only. A predicate writes only `res_mask`, a flag compare writes only `flags`, and a cycle without `in_valid` changes neither.
- R10: `inv_sticky` is set by each invalid event and stays set until `stat_clr`. If an invalid event and `stat_clr` arrive in the same cycle, the sticky bit ends up set.
- R11: Synchronous reset clears `res_mask`, `flags`, `wr_en`, `inv_now` and `inv_sticky`.
- R12: Positive and negative zero compare equal, and a magnitude-1 subnormal of either sign orders correctly against zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| opa | input | 64 | First operand (low 32 bits in binary32 mode) |
| opb | input | 64 | Second operand (low 32 bits in binary32 mode) |
| is_double | input | 1 | 1 = binary64, 0 = binary32 |
| op_sel | input | 3 | Operation select (see R2) |
| inv_mask | input | 1 | 1 = invalid condition masked |
| stat_clr | input | 1 | Clears the sticky invalid bit |
| res_mask | output | 64 | Predicate result mask |
| flags | output | 6 | Flag-compare status vector |
| wr_en | output | 1 | Result written this cycle |
| inv_now | output | 1 | Invalid raised by the operation just completed |
| inv_sticky | output | 1 | Accumulated invalid status |

## Verification
The sticky invalid bit can receive a new invalid event and a `stat_clr` in the same cycle. The bench provokes this with an unmasked signalling-NaN compare issued together with the clear. It then expects the sticky bit to read 1 and, on the following clear-only cycle, to read 0. The NaN sweep also meets a second collision on every unmasked invalid vector: the result write and the exception fall in one cycle. There the bench checks that the earlier mask and flags survive unchanged.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    parameter int SP_W    = 32;
    parameter int SP_EXP  = 8;
    parameter int SP_FRAC = 23;
    parameter int DP_W    = 64;
    parameter int DP_EXP  = 11;
    parameter int DP_FRAC = 52;
    parameter int FLG_W   = 6;

    typedef enum logic [2:0] {
        OP_EQ     = 3'd0,
        OP_LT     = 3'd1,
        OP_LE     = 3'd2,
        OP_UNORD  = 3'd3,
        OP_NLT    = 3'd4,
        OP_NLE    = 3'd5,
        OP_FSIG   = 3'd6,
        OP_FQUIET = 3'd7
    } cmp_op_e;

    typedef struct packed {
        logic            sign;
        logic            zero;
        logic            nan;
        logic            snan;
        logic [DP_W-2:0] mag;
    } fp_class_t;

    typedef struct packed {
        logic lt;
        logic eq;
        logic unord;
    } rel_t;

    // flag vector: [5] ovf, [4] sign, [3] aux, [2] zero, [1] parity, [0] carry
    localparam logic [FLG_W-1:0] FLG_GT = 6'b000000;
    localparam logic [FLG_W-1:0] FLG_LT = 6'b000001;
    localparam logic [FLG_W-1:0] FLG_EQ = 6'b000100;
    localparam logic [FLG_W-1:0] FLG_UN = 6'b000111;

    function automatic logic op_is_signalling(cmp_op_e op);
        return (op == OP_LT) || (op == OP_LE) || (op == OP_NLT) ||
               (op == OP_NLE) || (op == OP_FSIG);
    endfunction

    function automatic logic op_is_flag(cmp_op_e op);
        return (op == OP_FSIG) || (op == OP_FQUIET);
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  logic [DP_W-1:0] raw,
    input  logic            is_double,
    output fp_class_t       cls
);
    logic exp_all1;
    logic frac_nz;
    logic qbit;

    always_comb begin
        cls = '0;
        if (is_double) begin
            cls.sign = raw[DP_W-1];
            exp_all1 = &raw[DP_W-2 -: DP_EXP];
            frac_nz  = |raw[DP_FRAC-1:0];
            qbit     = raw[DP_FRAC-1];
            cls.mag  = raw[DP_W-2:0];
        end else begin
            cls.sign = raw[SP_W-1];
            exp_all1 = &raw[SP_W-2 -: SP_EXP];
            frac_nz  = |raw[SP_FRAC-1:0];
            qbit     = raw[SP_FRAC-1];
            cls.mag  = {{(DP_W-SP_W){1'b0}}, raw[SP_W-2:0]};
        end
        cls.nan  = exp_all1 && frac_nz;
        cls.snan = cls.nan && !qbit;
        cls.zero = (cls.mag == '0);
    end

    always_comb begin
        AST_SNAN_IS_NAN: assert (!cls.snan || cls.nan); // R1
    end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
(
    input  fp_class_t a,
    input  fp_class_t b,
    output rel_t      rel
);
    logic mag_lt;
    logic mag_gt;
    logic ord_lt;

    always_comb begin
        mag_lt    = a.mag < b.mag;
        mag_gt    = b.mag < a.mag;
        rel.unord = a.nan || b.nan;
        rel.eq    = !rel.unord &&
                    ((a.zero && b.zero) || (a.sign == b.sign && a.mag == b.mag));
        if (a.sign != b.sign) ord_lt = a.sign;
        else if (a.sign)      ord_lt = mag_gt;
        else                  ord_lt = mag_lt;
        rel.lt = !rel.unord && !rel.eq && ord_lt;
    end

    always_comb begin
        AST_REL_EXCL: assert ($countones({rel.lt, rel.eq, rel.unord}) <= 1); // R5
    end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DP_W-1:0]  opa,
    input  logic [DP_W-1:0]  opb,
    input  logic             is_double,
    input  logic [2:0]       op_sel,
    input  logic             inv_mask,
    input  logic             stat_clr,
    output logic [DP_W-1:0]  res_mask,
    output logic [FLG_W-1:0] flags,
    output logic             wr_en,
    output logic             inv_now,
    output logic             inv_sticky
);
    localparam int               NOPS    = 2;
    localparam logic [DP_W-1:0]  SP_ONES = {{(DP_W-SP_W){1'b0}}, {SP_W{1'b1}}};
    localparam logic [DP_W-1:0]  DP_ONES = {DP_W{1'b1}};

    logic [DP_W-1:0] raw [NOPS];
    fp_class_t       cls [NOPS];
    rel_t            rel;
    cmp_op_e         op;

    assign raw[0] = opa;
    assign raw[1] = opb;
    assign op     = cmp_op_e'(op_sel);

    for (genvar i = 0; i < NOPS; i++) begin : g_cls
        fcmp_classify u_cls (
            .raw       (raw[i]),
            .is_double (is_double),
            .cls       (cls[i])
        );
    end

    fcmp_relate u_rel (
        .a   (cls[0]),
        .b   (cls[1]),
        .rel (rel)
    );

    logic             pred_true;
    logic [DP_W-1:0]  mask_val;
    logic [FLG_W-1:0] flag_val;
    logic             invalid;
    logic             do_write;
    logic             inv_evt;

    always_comb begin
        unique case (op)
            OP_EQ:    pred_true = rel.eq;
            OP_LT:    pred_true = rel.lt;
            OP_LE:    pred_true = rel.lt || rel.eq;
            OP_UNORD: pred_true = rel.unord;
            OP_NLT:   pred_true = rel.unord || !rel.lt;
            OP_NLE:   pred_true = rel.unord || !(rel.lt || rel.eq);
            default:  pred_true = 1'b0;
        endcase
        mask_val = pred_true ? (is_double ? DP_ONES : SP_ONES) : '0;

        if (rel.unord)   flag_val = FLG_UN;
        else if (rel.eq) flag_val = FLG_EQ;
        else if (rel.lt) flag_val = FLG_LT;
        else             flag_val = FLG_GT;

        invalid  = op_is_signalling(op) ? rel.unord : (cls[0].snan || cls[1].snan);
        inv_evt  = in_valid && invalid;
        do_write = in_valid && !(invalid && !inv_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_mask   <= '0;
            flags      <= '0;
            wr_en      <= 1'b0;
            inv_now    <= 1'b0;
            inv_sticky <= 1'b0;
        end else begin
            wr_en      <= do_write;
            inv_now    <= inv_evt;
            inv_sticky <= (stat_clr ? 1'b0 : inv_sticky) | inv_evt;
            if (do_write) begin
                if (op_is_flag(op)) flags    <= flag_val;
                else                res_mask <= mask_val;
            end
        end
    end

    AST_SUPPRESS_WR: assert property (@(posedge clk) disable iff (rst)
        (inv_now && !$past(inv_mask)) |-> !wr_en); // R8

    AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> ($stable(res_mask) && $stable(flags))); // R9

    AST_FLAG_LEGAL: assert property (@(posedge clk) disable iff (rst)
        flags[5:3] == 3'b000 && ($onehot0(flags[2:0]) || flags[2:0] == 3'b111)); // R5

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        inv_now |-> inv_sticky); // R10

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (inv_sticky && !stat_clr) |=> inv_sticky); // R10

    AST_SP_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !$past(is_double) && $past(op_sel) < 3'd6) |-> res_mask[63:32] == '0); // R2
endmodule

// File: tb/fcmp_unit_test.sv
`timescale 1ns/1ps
module fcmp_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic        is_double = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        inv_mask = 1'b1;
    logic        stat_clr = 1'b0;
    logic [63:0] res_mask;
    logic [5:0]  flags;
    logic        wr_en, inv_now, inv_sticky;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] e_mask = '0;
    logic [5:0]  e_flags = '0;
    logic        e_sticky = 1'b0;

    always #4 clk = ~clk;

    fcmp_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
        .is_double(is_double), .op_sel(op_sel), .inv_mask(inv_mask),
        .stat_clr(stat_clr), .res_mask(res_mask), .flags(flags),
        .wr_en(wr_en), .inv_now(inv_now), .inv_sticky(inv_sticky)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] fp_val(int idx, bit dbl);
        logic [31:0] s;
        logic [63:0] d;
        case (idx)
            0:  begin s = 32'h00000000; d = 64'h0000000000000000; end
            1:  begin s = 32'h80000000; d = 64'h8000000000000000; end
            2:  begin s = 32'h3F800000; d = 64'h3FF0000000000000; end
            3:  begin s = 32'hBF800000; d = 64'hBFF0000000000000; end
            4:  begin s = 32'h40000000; d = 64'h4000000000000000; end
            5:  begin s = 32'hC0000000; d = 64'hC000000000000000; end
            6:  begin s = 32'h7F800000; d = 64'h7FF0000000000000; end
            7:  begin s = 32'hFF800000; d = 64'hFFF0000000000000; end
            8:  begin s = 32'h00000001; d = 64'h0000000000000001; end
            9:  begin s = 32'h80000001; d = 64'h8000000000000001; end
            10: begin s = 32'h7FC00000; d = 64'h7FF8000000000000; end
            11: begin s = 32'h7F800001; d = 64'h7FF0000000000001; end
            12: begin s = 32'hFFC00123; d = 64'hFFF8000000000123; end
            default: begin s = 32'h7FA00000; d = 64'h7FF4000000000000; end
        endcase
        return dbl ? d : {32'hA5A55A5A, s};
    endfunction

    function automatic int rank(int idx);
        case (idx)
            0, 1: return 0;
            2: return 2;   3: return -2;
            4: return 3;   5: return -3;
            6: return 9;   7: return -9;
            8: return 1;   9: return -1;
            default: return 100;
        endcase
    endfunction

    task automatic apply(int ia, int ib, int op, bit dbl, bit msk, bit clr);
        bit unord, sn, lt, eq, pt, sig, inv, we;
        logic [63:0] ones;
        // idle cycle before: nothing may change (R9)
        @(negedge clk);
        chk("R9", {63'b0, wr_en}, 64'd0);
        chk("R9", res_mask, e_mask);
        chk("R9", {58'b0, flags}, {58'b0, e_flags});
        in_valid = 1'b1; opa = fp_val(ia, dbl); opb = fp_val(ib, dbl);
        is_double = dbl; op_sel = op[2:0]; inv_mask = msk; stat_clr = clr;
        @(negedge clk);
        in_valid = 1'b0; stat_clr = 1'b0;
        unord = (ia >= 10) || (ib >= 10);
        sn    = (ia == 11) || (ia == 13) || (ib == 11) || (ib == 13);
        lt    = rank(ia) < rank(ib);
        eq    = rank(ia) == rank(ib);
        case (op)
            0: pt = !unord && eq;
            1: pt = !unord && lt;
            2: pt = !unord && (lt || eq);
            3: pt = unord;
            4: pt = unord || !lt;
            5: pt = unord || !(lt || eq);
            default: pt = 1'b0;
        endcase
        sig  = (op == 1) || (op == 2) || (op == 4) || (op == 5) || (op == 6);
        inv  = sig ? unord : sn;
        we   = !(inv && !msk);
        ones = dbl ? {64{1'b1}} : {32'b0, {32{1'b1}}};
        if (we) begin
            if (op < 6) e_mask = pt ? ones : 64'd0;
            else e_flags = unord ? 6'b000111 : eq ? 6'b000100 : lt ? 6'b000001 : 6'b000000;
        end
        e_sticky = (clr ? 1'b0 : e_sticky) | inv;
        chk("R8", {63'b0, wr_en}, {63'b0, we});
        chk(op < 6 ? "R4" : "R7", {63'b0, inv_now}, {63'b0, inv});
        chk((ia < 2 && ib < 2) ? "R12" : unord ? "R3" : "R2", res_mask, e_mask);
        chk(unord ? "R6" : "R5", {58'b0, flags}, {58'b0, e_flags});
        chk("R10", {63'b0, inv_sticky}, {63'b0, e_sticky});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11", res_mask, 64'd0);
        chk("R11", {58'b0, flags}, 64'd0);
        chk("R11", {61'b0, wr_en, inv_now, inv_sticky}, 64'd0);

        // R1: binary32 ignores a NaN-looking upper half
        @(negedge clk);
        in_valid = 1'b1; is_double = 1'b0; op_sel = 3'd6; inv_mask = 1'b0;
        opa = {32'h7FF80000, 32'h3F800000}; opb = {32'h7FF00001, 32'h3F800000};
        @(negedge clk);
        in_valid = 1'b0;
        e_flags = 6'b000100;
        chk("R1", {58'b0, flags}, {58'b0, e_flags});
        chk("R1", {62'b0, wr_en, inv_now}, 64'd2);

        // exhaustive sweep over the operand set, ops, precisions, masks
        for (int d = 0; d < 2; d++)
            for (int m = 0; m < 2; m++)
                for (int op = 0; op < 8; op++)
                    for (int ia = 0; ia < 14; ia++)
                        for (int ib = 0; ib < 14; ib++)
                            apply(ia, ib, op, d[0], m[0], 1'b0);

        // R10: clear alone, then clear colliding with a new invalid event
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        e_sticky = 1'b0;
        chk("R10", {63'b0, inv_sticky}, 64'd0);
        apply(11, 2, 7, 1'b0, 1'b0, 1'b0);
        apply(13, 0, 6, 1'b1, 1'b0, 1'b1);
        chk("R10", {63'b0, inv_sticky}, 64'd1);
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        e_sticky = 1'b0;
        chk("R10", {63'b0, inv_sticky}, 64'd0);
        apply(10, 2, 7, 1'b1, 1'b0, 1'b0);
        chk("R7", {63'b0, inv_sticky}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule